// File: doc/BRIEF.md
# Bus Acknowledge Wait-State Generator

This block produces the active-low data-transfer acknowledge for an 8-bit asynchronous microprocessor bus. Once a bus cycle has started, the processor waits until the acknowledge arrives. The block receives the address strobe, the data strobe, the read/write line and the device select lines, which are already decoded elsewhere. It then decides when the current cycle may end.

Fast on-board devices are answered pseudo-synchronously, after a fixed number of clocks. A write takes one clock longer than a read. Two slow device classes are handled differently: a serial controller and a slave shared RAM. Selecting either one raises a slow-cycle condition, which is registered into a hold-off. While the hold-off is active, the acknowledge is withheld until one of the two external handshake inputs arrives.

The strobes and both handshake inputs pass through two-flop synchronisers, and that latency is part of every wait count given below. If no device is selected, the acknowledge never comes. Ending such a cycle is left to a bus-error timer outside this block.

Top module: `dtack_waitgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dtack_n` is high after that edge, whatever the strobes and selects do.
- R2: For a read (`rd_wr_n` = 1) to a fast device (any bit of `dev_sel_fast` high), `dtack_n` goes low on the 3rd rising clock edge after `as_n` and `ds_n` go low together: two synchroniser stages plus one edge.
- R3: For a write (`rd_wr_n` = 0) to a fast device, `dtack_n` goes low on the 4th rising edge after the strobes go low, one clock later than a read.
- R4: When `dev_sel_uart` or `dev_sel_shram` is high, `dtack_n` stays high for as long as neither `uart_ack_n` nor `shram_ack_n` is low, however long that lasts.
- R5: In a serial-controller cycle, `dtack_n` goes low on the 3rd rising edge after `uart_ack_n` falls, provided the hold-off has been active for at least one clock.
- R6: In a shared-RAM cycle, `dtack_n` goes low on the 3rd rising edge after `shram_ack_n` falls, under the same condition.
- R7: Once low, `dtack_n` stays low while `as_n` stays low. It returns high on the 3rd rising edge after `as_n` rises, and all hold-off and wait state is cleared at that same edge.
- R8: If no select line is high during a strobed cycle, `dtack_n` never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (8 MHz in the target system) |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| dev_sel_fast | input | NUM_FAST | Decoded selects of fast on-board devices, active high |
| dev_sel_uart | input | 1 | Serial controller select, active high |
| dev_sel_shram | input | 1 | Slave shared RAM select, active high |
| uart_ack_n | input | 1 | Serial controller handshake, active low, asynchronous |
| shram_ack_n | input | 1 | Shared RAM handshake, active low, asynchronous |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |

## Verification
Fast reads and fast writes go to randomly chosen fast select bits. This separates the one-clock difference between the read and write counts, and it shows that every select bit is decoded. Slow cycles use a random handshake delay. A long delay shows that the hold-off really blocks the acknowledge, and the exact latency after the handshake separates the serial-controller path from the shared-RAM path. Cycles with no select at all confirm that the acknowledge is never given spontaneously. Every cycle ends with an exact count of the release latency, and held cycles of random length confirm that the acknowledge stays low until the strobe is released.

// File: rtl/dtw_pkg.sv
// Package dtw_pkg
// Purpose : shared constants and types for the acknowledge generator.
// Assumes : nothing; pure declarations.
package dtw_pkg;

    // Default wait clocks counted after the synchronised data strobe is seen.
    localparam int unsigned DTW_RD_WAIT = 0;
    localparam int unsigned DTW_WR_WAIT = 1;

    // Kind of bus cycle as seen by the control logic.
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_FAST = 2'd1,
        CYC_SLOW = 2'd2,
        CYC_NONE = 2'd3
    } cyc_kind_e;

    // Synchronised view of the asynchronous inputs, active high.
    typedef struct packed {
        logic as_on;
        logic ds_on;
        logic uart_ack;
        logic shram_ack;
    } sync_bus_t;

endpackage

// File: rtl/dtw_sync.sv
// Module dtw_sync
// Purpose : multi-bit, multi-stage flop synchroniser for independent
//           asynchronous single-bit signals.
// Assumes : each bit is an unrelated level signal, so no bus coherence is
//           needed; reset loads RST_VAL into every stage.
module dtw_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Pass the value one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dtw_fast_timer.sv
// Module dtw_fast_timer
// Purpose : counts wait clocks for a fast-device cycle and raises fast_go
//           once the read or write wait count is used up.
// Assumes : strobe_on is the synchronised AND of address and data strobe;
//           is_read is stable while the strobe is on.
module dtw_fast_timer #(
    parameter int unsigned RD_WAIT = 0,
    parameter int unsigned WR_WAIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_on,
    input  logic enable,
    input  logic is_read,
    output logic fast_go
);

    localparam int unsigned MAX_WAIT = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 2);
    localparam logic [CNT_W-1:0] RD_LIM = CNT_W'(RD_WAIT);
    localparam logic [CNT_W-1:0] WR_LIM = CNT_W'(WR_WAIT);

    logic [CNT_W-1:0] wait_q;
    logic [CNT_W-1:0] need;
    logic             done;

    // Select the wait count that applies to the current direction.
    always_comb begin
        need = is_read ? RD_LIM : WR_LIM;
        done = (wait_q >= need);
    end

    assign fast_go = enable && strobe_on && done;

    // Count clocks since the strobes were seen; clear between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          wait_q <= '0;
        else if (!strobe_on) wait_q <= '0;
        else if (!done)      wait_q <= wait_q + 1'b1;
    end

endmodule

// File: rtl/dtw_holdoff.sv
// Module dtw_holdoff
// Purpose : registers the slow-cycle condition into an active-low hold-off
//           and releases the slow acknowledge once a handshake is seen.
// Assumes : slow_sel comes from the decoded selects, stable during a cycle;
//           the handshake inputs are already synchronised.
module dtw_holdoff (
    input  logic clk,
    input  logic rst_n,
    input  logic as_on,
    input  logic ds_on,
    input  logic slow_sel,
    input  logic uart_ack,
    input  logic shram_ack,
    output logic holdoff_n,
    output logic slow_go
);

    logic slow_flag;

    // Combinational slow-cycle condition, valid only inside a strobed cycle.
    always_comb begin
        slow_flag = as_on && slow_sel;
    end

    // Register the slow condition into the hold-off, cleared with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      holdoff_n <= 1'b1;
        else if (!as_on) holdoff_n <= 1'b1;
        else             holdoff_n <= !slow_flag;
    end

    // A slow cycle may finish once the hold-off is armed and a handshake arrived.
    always_comb begin
        slow_go = !holdoff_n && ds_on && (uart_ack || shram_ack);
    end

endmodule

// File: rtl/dtack_waitgen.sv
// Module dtack_waitgen
// Purpose : top of the acknowledge generator. Synchronises the strobes and
//           handshakes, times fast cycles, holds off slow cycles and drives
//           the registered active-low acknowledge.
// Assumes : selects are decoded from a stable address while as_n is low;
//           at most one class (fast or slow) is selected per cycle.
module dtack_waitgen #(
    parameter int unsigned NUM_FAST    = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RD_WAIT     = dtw_pkg::DTW_RD_WAIT,
    parameter int unsigned WR_WAIT     = dtw_pkg::DTW_WR_WAIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                as_n,
    input  logic                ds_n,
    input  logic                rd_wr_n,
    input  logic [NUM_FAST-1:0] dev_sel_fast,
    input  logic                dev_sel_uart,
    input  logic                dev_sel_shram,
    input  logic                uart_ack_n,
    input  logic                shram_ack_n,
    output logic                dtack_n
);

    import dtw_pkg::*;

    localparam int unsigned SYNC_W = $bits(sync_bus_t);

    logic [SYNC_W-1:0] raw_n;
    logic [SYNC_W-1:0] syn_n;
    sync_bus_t         sb;
    logic              fast_any;
    logic              slow_sel;
    logic              fast_go;
    logic              slow_go;
    logic              holdoff_n;
    cyc_kind_e         kind;

    assign raw_n = {as_n, ds_n, uart_ack_n, shram_ack_n};

    dtw_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({SYNC_W{1'b1}})
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_n),
        .sync_o (syn_n)
    );

    // Turn the synchronised active-low inputs into active-high flags.
    always_comb begin
        sb = sync_bus_t'(~syn_n);
    end

    // Classify the current cycle from the decoded selects.
    always_comb begin
        fast_any = |dev_sel_fast;
        slow_sel = dev_sel_uart || dev_sel_shram;
        if (!sb.as_on)     kind = CYC_IDLE;
        else if (slow_sel) kind = CYC_SLOW;
        else if (fast_any) kind = CYC_FAST;
        else               kind = CYC_NONE;
    end

    dtw_fast_timer #(
        .RD_WAIT(RD_WAIT),
        .WR_WAIT(WR_WAIT)
    ) i_fast (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_on(sb.as_on && sb.ds_on),
        .enable   ((kind == CYC_FAST) && holdoff_n),
        .is_read  (rd_wr_n),
        .fast_go  (fast_go)
    );

    dtw_holdoff i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_on    (sb.as_on),
        .ds_on    (sb.ds_on),
        .slow_sel (slow_sel),
        .uart_ack (sb.uart_ack),
        .shram_ack(sb.shram_ack),
        .holdoff_n(holdoff_n),
        .slow_go  (slow_go)
    );

    // Drive the acknowledge: set on a go condition, held until the strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                  dtack_n <= 1'b1;
        else if (!sb.as_on)          dtack_n <= 1'b1;
        else if (fast_go || slow_go) dtack_n <= 1'b0;
    end

endmodule

// File: rtl/dtack_waitgen_chk.sv
// Module dtack_waitgen_chk
// Purpose : port-level temporal checks for dtack_waitgen, bound to it.
// Assumes : the two-stage synchroniser default.
module dtack_waitgen_chk #(
    parameter int unsigned NUM_FAST = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                as_n,
    input logic                ds_n,
    input logic                rd_wr_n,
    input logic [NUM_FAST-1:0] dev_sel_fast,
    input logic                dev_sel_uart,
    input logic                dev_sel_shram,
    input logic                uart_ack_n,
    input logic                shram_ack_n,
    input logic                dtack_n
);

    // R1
    reset_high_chk: assert property (@(posedge clk) !rst_n |=> dtack_n);

    // R7
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n && $past(as_n) && $past(as_n, 2)) |=> dtack_n);

    // R7
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !as_n && !$past(as_n) && !$past(as_n, 2)) |=> !dtack_n);

    // R8
    need_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past((|dev_sel_fast) || dev_sel_uart || dev_sel_shram));

    // R4
    slow_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dtack_n) && $past(dev_sel_uart || dev_sel_shram))
            |-> $past(!uart_ack_n || !shram_ack_n, 3));

endmodule

bind dtack_waitgen dtack_waitgen_chk #(.NUM_FAST(NUM_FAST)) i_chk (.*);

// File: tb/test_dtack_waitgen.sv
// Bench for dtack_waitgen: mixed directed and seeded random bus cycles.
module test_dtack_waitgen;

    localparam int NF = 4;
    localparam int LIMIT = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          as_n = 1'b1, ds_n = 1'b1, rd_wr_n = 1'b1;
    logic [NF-1:0] dev_sel_fast = '0;
    logic          dev_sel_uart = 1'b0, dev_sel_shram = 1'b0;
    logic          uart_ack_n = 1'b1, shram_ack_n = 1'b1;
    logic          dtack_n;
    int            total = 0;
    int            bad = 0;

    always #10 clk = ~clk;

    dtack_waitgen #(.NUM_FAST(NF)) i_dtack_waitgen (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .rd_wr_n(rd_wr_n),
        .dev_sel_fast(dev_sel_fast), .dev_sel_uart(dev_sel_uart),
        .dev_sel_shram(dev_sel_shram), .uart_ack_n(uart_ack_n),
        .shram_ack_n(shram_ack_n), .dtack_n(dtack_n)
    );

    // Expected latencies, from the requirements.
    function automatic int exp_fast(input logic rd);
        return rd ? 3 : 4;
    endfunction
    function automatic int exp_ack();
        return 3;
    endfunction
    function automatic int exp_release();
        return 3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count rising edges until dtack_n equals lvl; sampled at falling edges.
    task automatic edges_to(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (dtack_n !== lvl && n < LIMIT);
    endtask

    task automatic release_cycle();
        int n;
        as_n = 1'b1; ds_n = 1'b1; uart_ack_n = 1'b1; shram_ack_n = 1'b1;
        edges_to(1'b1, n);
        check(n == exp_release(), "R7 release latency", n, exp_release());
        dev_sel_fast = '0; dev_sel_uart = 1'b0; dev_sel_shram = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic fast_cycle(input int idx, input logic rd, input int hold);
        int n;
        bit stay;
        dev_sel_fast = '0;
        dev_sel_fast[idx] = 1'b1;
        rd_wr_n = rd; as_n = 1'b0; ds_n = 1'b0;
        edges_to(1'b0, n);
        if (rd) check(n == exp_fast(rd), "R2 fast read latency", n, exp_fast(rd));
        else    check(n == exp_fast(rd), "R3 fast write latency", n, exp_fast(rd));
        stay = 1'b1;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (dtack_n !== 1'b0) stay = 1'b0;
        end
        check(stay, "R7 held low", int'(dtack_n), 0);
        release_cycle();
    endtask

    task automatic slow_cycle(input bit use_uart, input int dly);
        int n;
        bit quiet;
        dev_sel_uart = use_uart; dev_sel_shram = !use_uart;
        rd_wr_n = $urandom_range(1, 0) != 0;
        as_n = 1'b0; ds_n = 1'b0;
        quiet = 1'b1;
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            if (dtack_n !== 1'b1) quiet = 1'b0;
        end
        check(quiet, "R4 hold-off before handshake", int'(dtack_n), 1);
        if (use_uart) uart_ack_n = 1'b0;
        else          shram_ack_n = 1'b0;
        edges_to(1'b0, n);
        if (use_uart) check(n == exp_ack(), "R5 serial ack latency", n, exp_ack());
        else          check(n == exp_ack(), "R6 shared RAM ack latency", n, exp_ack());
        release_cycle();
    endtask

    task automatic none_cycle();
        bit quiet;
        dev_sel_fast = '0; dev_sel_uart = 1'b0; dev_sel_shram = 1'b0;
        as_n = 1'b0; ds_n = 1'b0;
        quiet = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (dtack_n !== 1'b1) quiet = 1'b0;
        end
        check(quiet, "R8 no select", int'(dtack_n), 1);
        as_n = 1'b1; ds_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: strobes and selects active during reset
        as_n = 1'b0; ds_n = 1'b0; dev_sel_fast = 4'b0001;
        uart_ack_n = 1'b0;
        repeat (6) @(negedge clk);
        check(dtack_n === 1'b1, "R1 reset state", int'(dtack_n), 1);
        as_n = 1'b1; ds_n = 1'b1; dev_sel_fast = '0; uart_ack_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(dtack_n === 1'b1, "R1 idle after reset", int'(dtack_n), 1);

        // Directed corners
        fast_cycle(0, 1'b1, 0);
        fast_cycle(NF - 1, 1'b0, 5);
        slow_cycle(1'b1, 3);
        slow_cycle(1'b0, 3);
        slow_cycle(1'b1, 30);
        slow_cycle(1'b0, 30);
        none_cycle();

        // Seeded random mix
        for (int t = 0; t < 60; t++) begin
            case ($urandom_range(4, 0))
                0, 1: fast_cycle(int'($urandom_range(NF - 1, 0)),
                                 $urandom_range(1, 0) != 0,
                                 int'($urandom_range(6, 0)));
                2:    slow_cycle(1'b1, int'($urandom_range(12, 3)));
                3:    slow_cycle(1'b0, int'($urandom_range(12, 3)));
                default: none_cycle();
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule